// File: doc/BRIEF.md
# Dual-Channel Shadowed Compare Unit

This block watches a free-running 32-bit count supplied from outside and compares it against two independent 32-bit compare values. When a channel's value equals the count and that channel is enabled, a registered match pulse appears on the following clock. Each channel can also run with a shadow register: new values written by software wait in the shadow and only take effect on the clock where the count reaches the value currently in use. This lets software queue the next compare point without disturbing the one that is about to fire.

Software reaches the block over a narrow byte bus. A channel's compare value is written at one address as four byte accesses, lowest byte first. The word is assembled in a staging register and committed only when the top byte arrives, so a half-written value never takes part in a compare. A small control register holds the per-channel enable and shadow-mode bits. Compare values come up undefined in hardware terms, so the first value must be loaded with shadowing off.

Top module: `timer_compare_pair`

## Requirements
- R1: While reset is held and on the first clock after it, both match outputs are 0, the control register reads 0x00 (all enables and shadow-mode bits clear), and the compare registers read 0.
- R2: A channel's match output is 1 for the single clock following a clock on which the count equals that channel's compare value in use while its enable bit is 1; with the enable bit 0 it stays 0.
- R3: A channel that has never received a full committed word with shadow mode off never raises its match output, even when the count equals its reset value of 0.
- R4: Writes at a channel address with byte select 0, 1, 2 only fill the staging register; the compare value in use and its readback stay unchanged until byte select 3 is written, which commits {byte3, byte2, byte1, byte0}.
- R5: With a channel's shadow-mode bit 0, committing a word updates the compare value in use and the shadow together, and the new value is readable and matchable from the next clock.
- R6: With a channel's shadow-mode bit 1, committing a word updates only the shadow; the compare value in use, its readback and its matching are unchanged.
- R7: With shadow mode 1, on the clock edge where the match output rises the shadow is copied into the compare value in use, so the copied value applies to counts presented from then on.
- R8: The control register is at address 0, byte select 0: bits [1:0] are the enables for channels 1:0, bits [3:2] the shadow-mode bits for channels 1:0, bits [7:4] read 0; byte selects 1 to 3 at address 0 read 0x00 and writes there are ignored.
- R9: Channel 0 sits at address 1 and channel 1 at address 2; writing one channel never changes the other's value, shadow or match.
- R10: A read at a channel address returns byte number byteSel (0 = least significant) of the compare value in use, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| count | input | 32 | Current value of the external up-counter |
| busWe | input | 1 | Byte write strobe, captured on the rising clock edge |
| busAddr | input | 2 | 0 control, 1 channel 0, 2 channel 1, 3 unused (reads 0) |
| busByte | input | 2 | Byte select within the addressed register |
| busWdata | input | 8 | Write data byte |
| busRdata | output | 8 | Read data byte for busAddr/busByte |
| matchOut | output | 2 | Registered match pulse per channel |

## Verification
The hardest state to reach is a shadowed channel whose pending value differs from the value in use at the very moment the count arrives at the old value, because it needs the value loaded directly first, shadow mode switched on, a second word written, and only then the count stepped onto the old value. The stimulus walks exactly that path, then presents the old value again on the next clock to show it no longer matches, and finally presents the new value to show the copy took effect. Partial writes are probed by reading back between the third and fourth byte.

// File: rtl/tcp_pkg.sv
package tcp_pkg;
  localparam int TCP_CH      = 2;
  localparam int TCP_CNT_W   = 32;
  localparam int TCP_BYTE_W  = 8;
  localparam int TCP_BYTES   = TCP_CNT_W / TCP_BYTE_W;
  localparam int TCP_BSEL_W  = $clog2(TCP_BYTES);
  localparam int TCP_ADDR_W  = 2;
  localparam int TCP_CTRL_ADDR = 0;

  // Strobes from the bus decoder to the compare datapath
  typedef struct packed {
    logic [TCP_CH-1:0]     stageWr;
    logic [TCP_CH-1:0]     commit;
    logic [TCP_BSEL_W-1:0] byteIdx;
    logic [TCP_BYTE_W-1:0] data;
  } tcpStrobe_t;
endpackage

// File: rtl/tcp_ctrl.sv
module tcp_ctrl
  import tcp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWe,
  input  logic [TCP_ADDR_W-1:0] busAddr,
  input  logic [TCP_BSEL_W-1:0] busByte,
  input  logic [TCP_BYTE_W-1:0] busWdata,
  output tcpStrobe_t            strb,
  output logic [TCP_CH-1:0]     cmpEn,
  output logic [TCP_CH-1:0]     dbEn,
  output logic [TCP_BYTE_W-1:0] ctrlByte
);
  localparam logic [TCP_BSEL_W-1:0] LAST_BYTE = TCP_BSEL_W'(TCP_BYTES - 1);
  localparam logic [TCP_ADDR_W-1:0] CTRL_ADDR = TCP_ADDR_W'(TCP_CTRL_ADDR);

  logic ctrlWr;
  assign ctrlWr = busWe && (busAddr == CTRL_ADDR) && (busByte == '0);

  always_comb begin
    strb         = '0;
    strb.byteIdx = busByte;
    strb.data    = busWdata;
    for (int c = 0; c < TCP_CH; c++) begin
      if (busWe && (busAddr == TCP_ADDR_W'(TCP_CTRL_ADDR + 1 + c))) begin
        if (busByte == LAST_BYTE) strb.commit[c]  = 1'b1;
        else                      strb.stageWr[c] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpEn <= '0;
      dbEn  <= '0;
    end else if (ctrlWr) begin
      cmpEn <= busWdata[TCP_CH-1:0];
      dbEn  <= busWdata[2*TCP_CH-1:TCP_CH];
    end
  end

  assign ctrlByte = TCP_BYTE_W'({dbEn, cmpEn});
endmodule

// File: rtl/tcp_dpath.sv
module tcp_dpath
  import tcp_pkg::*;
(
  input  logic                                clk,
  input  logic                                rstN,
  input  tcpStrobe_t                          strb,
  input  logic [TCP_CH-1:0]                   cmpEn,
  input  logic [TCP_CH-1:0]                   dbEn,
  input  logic [TCP_CNT_W-1:0]                count,
  output logic [TCP_CH-1:0]                   matchOut,
  output logic [TCP_CH-1:0][TCP_CNT_W-1:0]    activeVec
);
  localparam int LOW_W = TCP_CNT_W - TCP_BYTE_W;

  for (genvar c = 0; c < TCP_CH; c++) begin : g_chan
    logic [TCP_CNT_W-1:0] stage;
    logic [TCP_CNT_W-1:0] shadow;
    logic [TCP_CNT_W-1:0] active;
    logic [TCP_CNT_W-1:0] word;
    logic                 loaded;
    logic                 hit;
    logic                 fire;

    assign word = {strb.data, stage[LOW_W-1:0]};
    assign hit  = loaded && (count == active);
    assign fire = hit && cmpEn[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage    <= '0;
        shadow   <= '0;
        active   <= '0;
        loaded   <= 1'b0;
        matchOut[c] <= 1'b0;
      end else begin
        matchOut[c] <= fire;
        if (strb.stageWr[c]) begin
          stage[strb.byteIdx*TCP_BYTE_W +: TCP_BYTE_W] <= strb.data;
        end
        if (fire && dbEn[c]) begin
          active <= shadow;
        end
        if (strb.commit[c]) begin
          shadow <= word;
          if (!dbEn[c]) begin
            active <= word;
            loaded <= 1'b1;
          end
        end
      end
    end

    assign activeVec[c] = active;
  end
endmodule

// File: rtl/timer_compare_pair.sv
module timer_compare_pair
  import tcp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [TCP_CNT_W-1:0]  count,
  input  logic                  busWe,
  input  logic [TCP_ADDR_W-1:0] busAddr,
  input  logic [TCP_BSEL_W-1:0] busByte,
  input  logic [TCP_BYTE_W-1:0] busWdata,
  output logic [TCP_BYTE_W-1:0] busRdata,
  output logic [TCP_CH-1:0]     matchOut
);
  tcpStrobe_t                       strb;
  logic [TCP_CH-1:0]                cmpEn;
  logic [TCP_CH-1:0]                dbEn;
  logic [TCP_BYTE_W-1:0]            ctrlByte;
  logic [TCP_CH-1:0][TCP_CNT_W-1:0] activeVec;

  tcp_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busByte  (busByte),
    .busWdata (busWdata),
    .strb     (strb),
    .cmpEn    (cmpEn),
    .dbEn     (dbEn),
    .ctrlByte (ctrlByte)
  );

  tcp_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpEn     (cmpEn),
    .dbEn      (dbEn),
    .count     (count),
    .matchOut  (matchOut),
    .activeVec (activeVec)
  );

  always_comb begin
    busRdata = '0;
    if (busAddr == TCP_ADDR_W'(TCP_CTRL_ADDR) && busByte == '0) begin
      busRdata = ctrlByte;
    end
    for (int c = 0; c < TCP_CH; c++) begin
      if (busAddr == TCP_ADDR_W'(TCP_CTRL_ADDR + 1 + c)) begin
        busRdata = activeVec[c][busByte*TCP_BYTE_W +: TCP_BYTE_W];
      end
    end
  end
endmodule

// File: rtl/tcp_checker.sv
module tcp_checker
  import tcp_pkg::*;
(
  input logic                                clk,
  input logic                                rstN,
  input logic [TCP_CNT_W-1:0]                count,
  input logic [TCP_ADDR_W-1:0]               busAddr,
  input logic [TCP_BSEL_W-1:0]               busByte,
  input logic [TCP_BYTE_W-1:0]               busRdata,
  input logic [TCP_CH-1:0]                   matchOut,
  input logic [TCP_CH-1:0]                   cmpEn,
  input logic [TCP_CH-1:0]                   dbEn,
  input tcpStrobe_t                          strb,
  input logic [TCP_CH-1:0][TCP_CNT_W-1:0]    activeVec
);
  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> matchOut == '0); // R1

  AST_ONE_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.commit)); // R9

  always_comb begin
    if (rstN && busAddr == TCP_ADDR_W'(TCP_CTRL_ADDR) && busByte != '0) begin
      AST_CTRL_HIGH_ZERO: assert (busRdata == '0); // R8
    end
  end

  for (genvar c = 0; c < TCP_CH; c++) begin : g_chk
    AST_MATCH_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      matchOut[c] |-> $past(cmpEn[c]) && ($past(count) == $past(activeVec[c]))); // R2

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!matchOut[c] && $past(dbEn[c])) |-> $stable(activeVec[c])); // R6

    AST_DIRECT_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
      ($past(strb.commit[c]) && !$past(dbEn[c])) |->
        activeVec[c][TCP_CNT_W-1 -: TCP_BYTE_W] == $past(strb.data)); // R5
  end
endmodule

bind timer_compare_pair tcp_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .count     (count),
  .busAddr   (busAddr),
  .busByte   (busByte),
  .busRdata  (busRdata),
  .matchOut  (matchOut),
  .cmpEn     (cmpEn),
  .dbEn      (dbEn),
  .strb      (strb),
  .activeVec (activeVec)
);

// File: tb/test_timer_compare_pair.sv
module test_timer_compare_pair;
  localparam logic [31:0] IDLE = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] count = IDLE;
  logic        busWe = 1'b0;
  logic [1:0]  busAddr = '0;
  logic [1:0]  busByte = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [1:0]  matchOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int       at;
    logic [1:0] exp;
    string    tag;
  } expItem_t;
  expItem_t expQ[$];

  logic [31:0] mAct[2];
  logic [31:0] mShd[2];
  logic [31:0] mStg[2];
  bit          mVal[2];
  logic [1:0]  mEn = '0;
  logic [1:0]  mDb = '0;

  timer_compare_pair i_timer_compare_pair (
    .clk(clk), .rstN(rstN), .count(count), .busWe(busWe), .busAddr(busAddr),
    .busByte(busByte), .busWdata(busWdata), .busRdata(busRdata), .matchOut(matchOut)
  );

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expected match vectors as the design produces them
  always @(negedge clk) begin
    while (expQ.size() > 0 && expQ[0].at <= cyc) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.tag, {30'd0, matchOut}, {30'd0, it.exp});
    end
  end

  task automatic busWr(logic [1:0] a, logic [1:0] b, logic [7:0] d);
    logic [31:0] w;
    int c;
    @(posedge clk); #1;
    busWe = 1'b1; busAddr = a; busByte = b; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
    if (a == 2'd0 && b == 2'd0) {mDb, mEn} = d[3:0];
    if (a == 2'd1 || a == 2'd2) begin
      c = int'(a) - 1;
      if (b != 2'd3) mStg[c][b*8 +: 8] = d;
      else begin
        w = {d, mStg[c][23:0]};
        mShd[c] = w;
        if (!mDb[c]) begin mAct[c] = w; mVal[c] = 1'b1; end
      end
    end
  endtask

  task automatic wrWord(int c, logic [31:0] w);
    for (int b = 0; b < 4; b++) busWr(2'(c + 1), 2'(b), w[b*8 +: 8]);
  endtask

  task automatic busRd(logic [1:0] a, logic [1:0] b, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    busAddr = a; busByte = b;
    @(negedge clk);
    check(tag, {24'd0, busRdata}, {24'd0, exp});
  endtask

  // Driver: presents a count and queues the match expected one clock later
  task automatic step(logic [31:0] v, string tag);
    expItem_t it;
    @(posedge clk); #1;
    count = v;
    it.exp = '0;
    for (int c = 0; c < 2; c++) begin
      if (mVal[c] && v == mAct[c] && mEn[c]) begin
        it.exp[c] = 1'b1;
        if (mDb[c]) mAct[c] = mShd[c];
      end
    end
    it.at = cyc + 1;
    it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic settle();
    step(IDLE, "idle");
    step(IDLE, "idle");
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      mAct[c] = '0; mShd[c] = '0; mStg[c] = '0; mVal[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 match in reset", {30'd0, matchOut}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 match after reset", {30'd0, matchOut}, 32'd0);
    busRd(2'd0, 2'd0, 8'h00, "R1 ctrl reset");
    busRd(2'd1, 2'd0, 8'h00, "R1 ch0 reset");

    // R3: enables on, nothing loaded, count equals reset value 0
    busWr(2'd0, 2'd0, 8'h03);
    step(32'd0, "R3 unloaded channel");
    settle();

    // R4: partial write leaves active value untouched
    busWr(2'd1, 2'd0, 8'h78);
    busWr(2'd1, 2'd1, 8'h56);
    busWr(2'd1, 2'd2, 8'h34);
    busRd(2'd1, 2'd0, 8'h00, "R4 partial byte0");
    busRd(2'd1, 2'd2, 8'h00, "R4 partial byte2");
    busWr(2'd1, 2'd3, 8'h12);
    busRd(2'd1, 2'd0, 8'h78, "R10 ch0 byte0");
    busRd(2'd1, 2'd1, 8'h56, "R10 ch0 byte1");
    busRd(2'd1, 2'd2, 8'h34, "R10 ch0 byte2");
    busRd(2'd1, 2'd3, 8'h12, "R4 R5 ch0 byte3");

    // R9: channel 1 write leaves channel 0 alone
    wrWord(1, 32'hA5A5_0001);
    busRd(2'd1, 2'd3, 8'h12, "R9 ch0 unchanged");
    busRd(2'd2, 2'd3, 8'hA5, "R9 ch1 byte3");
    busRd(2'd2, 2'd0, 8'h01, "R10 ch1 byte0");
    busRd(2'd3, 2'd0, 8'h00, "R10 unused address");

    // R2: matching on both channels
    step(32'h1234_5677, "R2 below");
    step(32'h1234_5678, "R2 ch0 hit");
    step(32'h1234_5679, "R2 above");
    step(32'hA5A5_0001, "R2 R9 ch1 hit");
    settle();

    // R8: control layout, high bits and other bytes
    busWr(2'd0, 2'd0, 8'hF1);
    busRd(2'd0, 2'd0, 8'h01, "R8 high bits read 0");
    busWr(2'd0, 2'd1, 8'hFF);
    busRd(2'd0, 2'd0, 8'h01, "R8 byte1 write ignored");
    busRd(2'd0, 2'd1, 8'h00, "R8 byte1 reads 0");
    step(32'hA5A5_0001, "R2 ch1 disabled");
    step(32'h1234_5678, "R2 ch0 enabled");
    settle();

    // R6 / R7: shadow mode on channel 0
    busWr(2'd0, 2'd0, 8'h07);
    busRd(2'd0, 2'd0, 8'h07, "R8 shadow bit");
    wrWord(0, 32'h0000_1000);
    busRd(2'd1, 2'd0, 8'h78, "R6 active kept");
    step(32'h0000_1000, "R6 shadow not live");
    step(32'h1234_5678, "R7 old value fires");
    step(32'h1234_5678, "R7 old value gone");
    step(32'h0000_1000, "R7 new value fires");
    settle();
    busRd(2'd1, 2'd1, 8'h10, "R7 active copied");
    busRd(2'd2, 2'd3, 8'hA5, "R9 ch1 untouched");

    // R5: direct mode again
    busWr(2'd0, 2'd0, 8'h03);
    wrWord(0, 32'h0000_00AA);
    busRd(2'd1, 2'd0, 8'hAA, "R5 direct byte0");
    busRd(2'd1, 2'd1, 8'h00, "R5 direct byte1");
    step(32'h0000_00AA, "R5 direct match");
    settle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule